// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

This block decides which of four DMA channels is serviced next. A channel takes part only when its request line and its enable line are both high. A single mode input selects one of two orders. In the fixed order, channel 0 always wins and channel 3 always loses. In the rotating order, the channel that was just serviced drops to last place.

Once a grant is issued, it is registered and held for the whole DMA cycle. A one-cycle end pulse releases it. The pulse carries the number of the channel that was serviced, and the rotating order is advanced only on that pulse. The sequencer around the block drives the end pulse and consumes the one-hot grant and its encoded channel number.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset, `gnt_o` is 0 and `gnt_id_o` is 0, and channel 0 has the highest priority.
- R2: A channel counts as qualified only when `req_i[n]` and `en_i[n]` are both 1. With no qualified channel, no grant is issued.
- R3: While no grant is held and `done_i` is 0, a qualified request is answered at the next clock edge. The answer is a one-hot `gnt_o`, and `gnt_id_o` holds the bit index of the granted channel.
- R4: A held grant does not change while `done_i` is 0, even if requests or enables change.
- R5: A cycle with `done_i`=1 clears the grant at the next edge. A new grant can appear no earlier than the edge after that.
- R6: With `rotate_i`=0, the lowest-numbered qualified channel wins.
- R7: With `rotate_i`=1, a `done_i` pulse naming channel c sets the order to c+1, c+2, … (wrapping modulo 4), so that c is lowest.
- R8: In rotating mode, the priority order changes only on a `done_i` pulse.
- R9: Any edge with `rotate_i`=0 restores the default order. Rotating mode entered afterwards starts with channel 0 highest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Per-channel service request |
| en_i | input | 4 | Per-channel enable |
| rotate_i | input | 1 | 1 selects rotating priority, 0 selects fixed priority |
| done_i | input | 1 | End-of-DMA-cycle pulse |
| done_ch_i | input | 2 | Number of the channel just serviced, valid with `done_i` |
| gnt_o | output | 4 | One-hot grant, all zero when idle |
| gnt_id_o | output | 2 | Encoded number of the granted channel, 0 when idle |

## Verification
The priority pointer is never visible on its own. A wrong pointer shows up only at the next arbitration in which at least two channels are qualified, as a grant to the wrong channel one edge after the grant is released. A stale or lost hold state shows up immediately: the grant changes under a steady cycle, or it survives a `done_i` pulse. The reference model keeps the order as an explicit queue and compares both outputs on every clock, so any divergence is reported in the cycle it first reaches the ports.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic {
    PRIO_FIXED  = 1'b0,
    PRIO_ROTATE = 1'b1
  } prio_mode_e;
endpackage

// File: rtl/arb_ptr.sv
module arb_ptr
  import dma_arb_pkg::*;
#(
  parameter int N_CH = 4,
  localparam int IDW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  prio_mode_e     mode_i,
  input  logic           done_i,
  input  logic [IDW-1:0] done_ch_i,
  output logic [IDW-1:0] ptr_o
);
  logic [IDW-1:0] ptr_q;

  // ptr_q is the channel with the highest priority
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ptr_q <= '0;
    else if (mode_i == PRIO_FIXED) ptr_q <= '0;
    else if (done_i) begin
      if (done_ch_i == IDW'(N_CH - 1)) ptr_q <= '0;
      else                             ptr_q <= done_ch_i + 1'b1;
    end
  end

  assign ptr_o = ptr_q;

  // R9
  fixed_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == PRIO_FIXED) |=> (ptr_o == '0));
  // R8
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == PRIO_ROTATE && !done_i) |=> $stable(ptr_o));
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int N_CH = 4,
  localparam int IDW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [N_CH-1:0] qual_i,
  input  logic [IDW-1:0]  ptr_i,
  output logic [N_CH-1:0] pick_o
);
  // search from ptr_i upward, wrapping
  always_comb begin
    int   idx;
    logic found;
    pick_o = '0;
    found  = 1'b0;
    idx    = 0;
    for (int k = 0; k < N_CH; k++) begin
      idx = int'(ptr_i) + k;
      if (idx >= N_CH) idx = idx - N_CH;
      if (!found && qual_i[idx]) begin
        pick_o[idx] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  // R2
  pick_valid_chk: assert final ((pick_o & ~qual_i) == '0);
endmodule

// File: rtl/arb_hold.sv
module arb_hold #(
  parameter int N_CH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            done_i,
  input  logic [N_CH-1:0] qual_i,
  input  logic [N_CH-1:0] pick_i,
  output logic [N_CH-1:0] gnt_o
);
  logic [N_CH-1:0] gnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          gnt_q <= '0;
    else if (done_i)      gnt_q <= '0;
    else if (gnt_q == '0) gnt_q <= pick_i;
  end

  assign gnt_o = gnt_q;

  // R3
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  // R3
  gnt_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == '0 && !done_i && qual_i != '0) |=> ((gnt_o & $past(qual_i)) != '0));
  // R2
  no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == '0 && qual_i == '0) |=> (gnt_o == '0));
  // R4
  gnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && !done_i) |=> $stable(gnt_o));
  // R5
  gnt_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (gnt_o == '0));
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dma_arb_pkg::*;
#(
  parameter int N_CH = 4,
  localparam int IDW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] req_i,
  input  logic [N_CH-1:0] en_i,
  input  logic            rotate_i,
  input  logic            done_i,
  input  logic [IDW-1:0]  done_ch_i,
  output logic [N_CH-1:0] gnt_o,
  output logic [IDW-1:0]  gnt_id_o
);
  logic [N_CH-1:0] qual, pick;
  logic [IDW-1:0]  ptr;
  prio_mode_e      mode;

  assign qual = req_i & en_i;
  assign mode = rotate_i ? PRIO_ROTATE : PRIO_FIXED;

  arb_ptr #(.N_CH(N_CH)) u_ptr (
    .clk_i, .rst_ni, .mode_i(mode), .done_i, .done_ch_i, .ptr_o(ptr)
  );

  arb_pick #(.N_CH(N_CH)) u_pick (
    .qual_i(qual), .ptr_i(ptr), .pick_o(pick)
  );

  arb_hold #(.N_CH(N_CH)) u_hold (
    .clk_i, .rst_ni, .done_i, .qual_i(qual), .pick_i(pick), .gnt_o
  );

  always_comb begin
    gnt_id_o = '0;
    for (int i = 0; i < N_CH; i++)
      if (gnt_o[i]) gnt_id_o = IDW'(i);
  end

  // R3
  id_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0) |-> gnt_o[gnt_id_o]);
  // R1
  idle_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == '0) |-> (gnt_id_o == '0));
endmodule

// File: tb/dma_prio_arbiter_tb.sv
module dma_prio_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0, en = '0;
  logic       rot = 1'b0, done = 1'b0;
  logic [1:0] dch = '0;
  logic [3:0] gnt;
  logic [1:0] gid;

  int    errs = 0, checks = 0, cyc = 0;
  string tag = "R1";
  int    order[$];
  int    m_gnt = -1;

  always #4 clk = ~clk;

  dma_prio_arbiter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .en_i(en), .rotate_i(rot),
    .done_i(done), .done_ch_i(dch), .gnt_o(gnt), .gnt_id_o(gid)
  );

  // behavioural reference: order held as a queue, highest first
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      order = '{0, 1, 2, 3};
      m_gnt = -1;
    end else begin
      int pick;
      pick = -1;
      foreach (order[i])
        if (pick < 0 && req[order[i]] && en[order[i]]) pick = order[i];
      if (done)            m_gnt = -1;
      else if (m_gnt < 0)  m_gnt = pick;
      if (!rot) order = '{0, 1, 2, 3};
      else if (done) begin
        while (order[$] != int'(dch)) order.push_back(order.pop_front());
      end
    end
  end

  task automatic check(input string t, input logic [3:0] g, input logic [1:0] id);
    logic [3:0] eg;
    logic [1:0] eid;
    eg  = (m_gnt < 0) ? 4'b0 : 4'(1 << m_gnt);
    eid = (m_gnt < 0) ? 2'd0 : 2'(m_gnt);
    checks++;
    if (g !== eg || id !== eid) begin
      errs++;
      $display("FAIL %s: gnt=%b id=%0d expected gnt=%b id=%0d", t, g, id, eg, eid);
    end
  endtask

  always @(negedge clk) if (rst_n) check(tag, gnt, gid);

  task automatic drive(input logic [3:0] r, e, input logic ro, dn, input logic [1:0] dc);
    @(negedge clk);
    #1;
    req = r; en = e; rot = ro; done = dn; dch = dc;
  endtask

  // end the held cycle for the granted channel
  task automatic finish_cycle(input logic [3:0] r, e, input logic ro);
    drive(r, e, ro, 1'b1, (m_gnt < 0) ? 2'd0 : 2'(m_gnt));
    drive(r, e, ro, 1'b0, 2'd0);
  endtask

  task automatic expect_id(input string t, input int ch);
    @(negedge clk);
    checks++;
    if (gnt !== 4'(1 << ch) || gid !== 2'(ch)) begin
      errs++;
      $display("FAIL %s: gnt=%b id=%0d expected channel %0d", t, gnt, gid, ch);
    end
  endtask

  initial begin
    int lfsr;
    #2;
    checks++;
    if (gnt !== 4'b0 || gid !== 2'd0) begin
      errs++;
      $display("FAIL R1: gnt=%b id=%0d expected 0000/0", gnt, gid);
    end
    #20 rst_n = 1'b1;

    tag = "R1";
    drive(4'hF, 4'hF, 1'b1, 1'b0, 2'd0);
    expect_id("R1", 0);
    finish_cycle(4'h0, 4'hF, 1'b1);

    tag = "R2";
    drive(4'hF, 4'h0, 1'b0, 1'b0, 2'd0);
    drive(4'h0, 4'hF, 1'b0, 1'b0, 2'd0);
    drive(4'hF, 4'hA, 1'b0, 1'b0, 2'd0);
    expect_id("R2", 1);
    finish_cycle(4'h0, 4'h0, 1'b0);

    tag = "R4";
    drive(4'h8, 4'hF, 1'b0, 1'b0, 2'd0);
    drive(4'h1, 4'hF, 1'b0, 1'b0, 2'd0);
    drive(4'h0, 4'h0, 1'b0, 1'b0, 2'd0);
    expect_id("R4", 3);

    tag = "R5";
    drive(4'hF, 4'hF, 1'b0, 1'b1, 2'd3);
    @(negedge clk);
    checks++;
    if (gnt !== 4'b0) begin
      errs++;
      $display("FAIL R5: gnt=%b expected 0000", gnt);
    end
    drive(4'hF, 4'hF, 1'b0, 1'b0, 2'd0);

    tag = "R6";
    for (int i = 0; i < 3; i++) finish_cycle(4'hE, 4'hF, 1'b0);
    expect_id("R6", 1);
    finish_cycle(4'h0, 4'hF, 1'b0);

    tag = "R7";
    drive(4'hF, 4'hF, 1'b1, 1'b0, 2'd0);
    expect_id("R7", 0);
    finish_cycle(4'hF, 4'hF, 1'b1);
    expect_id("R7", 1);
    finish_cycle(4'h5, 4'hF, 1'b1);
    expect_id("R7", 2);
    finish_cycle(4'h3, 4'hF, 1'b1);
    expect_id("R7", 0);
    finish_cycle(4'h0, 4'hF, 1'b1);

    tag = "R8";
    drive(4'h0, 4'hF, 1'b1, 1'b0, 2'd0);
    repeat (4) drive(4'h0, 4'hF, 1'b1, 1'b0, 2'd0);
    drive(4'hF, 4'hF, 1'b1, 1'b0, 2'd0);
    expect_id("R8", 1);
    finish_cycle(4'h0, 4'hF, 1'b1);

    tag = "R9";
    drive(4'h0, 4'hF, 1'b0, 1'b0, 2'd0);
    drive(4'hF, 4'hF, 1'b1, 1'b0, 2'd0);
    expect_id("R9", 0);
    finish_cycle(4'h0, 4'hF, 1'b1);

    tag = "R3";
    lfsr = 32'h1ACE5;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[3:1] == 3'd0 && m_gnt >= 0)
        drive(lfsr[7:4], lfsr[11:8] | 4'h3, lfsr[12] | lfsr[13], 1'b1, 2'(m_gnt));
      else
        drive(lfsr[7:4], lfsr[11:8] | 4'h3, lfsr[12] | lfsr[13], 1'b0, 2'(lfsr[15:14]));
    end
    drive(4'h0, 4'h0, 1'b0, 1'b0, 2'd0);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errs++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected < 20000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule